// File: doc/BRIEF.md
# External Bus Strobe Generator

This block times the external memory bus of an 8051-style microcontroller core. It runs from the oscillator clock and splits each machine cycle into four phases of equal length. From these phases it drives the address-latch strobe (active high), the program-store read strobe (active low), a selector that tells the port-0 pad logic which byte to drive, and a selector that picks the source for port 2. Instruction decoding and the address and data bytes themselves belong to the surrounding core. This block only says *when* each byte belongs on the pins.

Once per machine cycle, at its last clock, the block samples a bus-mode code, a read/write flag, the address-latch disable bit, and a flag that marks an instruction that reads external code or data. The sampled values govern the whole next machine cycle.

The timebase state machine has four states: `PH_ADDR_A`, `PH_STRB_A`, `PH_ADDR_B` and `PH_STRB_B`. Each state lasts `PHASE_LEN` clocks. The transitions run `PH_ADDR_A→PH_STRB_A` ("first address ends"), `PH_STRB_A→PH_ADDR_B` ("first strobe ends"), `PH_ADDR_B→PH_STRB_B` ("second address ends") and `PH_STRB_B→PH_ADDR_A` ("cycle wraps"). The sampling of the configuration happens on the "cycle wraps" transition.

Top module: `ext_bus_strobe`

## Requirements
With default parameters a machine cycle is 12 clocks, numbered t=0..11. Reset places the block at t=0. Bus-mode codes are: 00 internal code fetch, 01 external code fetch, 10 external data with 8-bit address, 11 external data with 16-bit address. Port-0 select codes are: 00 high impedance, 01 low address byte, 10 data byte. Port-2 select is 1 for the high address byte and 0 for the port-2 register.
- R1: During reset, ale=0, psen_n=1, p0_sel=00 and p2_sel=0. The first machine cycle after reset behaves as an internal fetch with the strobe enabled, whatever the inputs were.
- R2: The inputs present at the clock edge that ends t=11 govern the next machine cycle. When ALE is unsuppressed, it gives exactly two rising edges per 12-clock machine cycle, which is one-sixth of the clock rate.
- R3: In internal fetch (disable bit clear) and in external fetch, ale is 1 at t=1,2,7,8 and 0 otherwise.
- R4: In external fetch, psen_n is 0 at t=3..5 and t=9..11 and 1 otherwise. ale and psen_n=0 never coincide.
- R5: In internal fetch, psen_n stays 1, p0_sel stays 00 and p2_sel stays 0 for the whole cycle.
- R6: In an external data cycle (either width), ale is 1 only at t=1,2, because the second pulse is skipped. psen_n stays 1 for the whole cycle, because both read strobes are skipped.
- R7: In internal fetch with the disable bit set and the external-access flag clear, ale stays 0 for the whole cycle.
- R8: In internal fetch with the disable bit set and the external-access flag set, ale pulses as in R3.
- R9: In external fetch, the disable bit has no effect, and ale pulses as in R3.
- R10: In external fetch, p0_sel is 01 at t=0..2 and t=6..8 and 00 otherwise. The low address is therefore driven through the falling edge of ale.
- R11: In an external data cycle, p0_sel is 01 at t=0..2. For t=3..11 it is 00 for a read and 10 for a write.
- R12: p2_sel is 1 for the whole cycle in external fetch and 16-bit data cycles. It is 0 in internal fetch and 8-bit data cycles.
- R13: An input change inside a machine cycle leaves the rest of that cycle unchanged. The change takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_mode | input | 2 | Bus-mode code for the next machine cycle |
| data_wr | input | 1 | 1 when the data access is a write |
| ale_off | input | 1 | Address-latch strobe disable bit |
| xacc_instr | input | 1 | Instruction reads external code or data |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| p0_sel | output | 2 | Port-0 drive select |
| p2_sel | output | 1 | Port-2 source select |

## Verification
The directed scenarios target the following corner cases and the failure each would expose:
- **Pulse skipping in data cycles.** A design that skips nothing would show a second ale pulse and psen_n pulses in a data cycle. Skipping the wrong pulse moves the address strobe away from t=1,2.
- **Disable bit.** The disable bit is tried in internal fetch with and without the external-access flag, and in external fetch. A wrong gating either silences ale during external fetch or leaves it running when it should be quiet.
- **Data-cycle direction.** Read and write data cycles are separated by the port-0 select, so swapping the direction sense shows up as data driven during a read.
- **Mode change mid-cycle.** A change of mode in the middle of a cycle catches a design that samples its configuration continuously instead of at the cycle boundary.
- **First cycle after reset.** This cycle catches a reset value that does not match an internal fetch.

// File: rtl/esg_pkg.sv
package esg_pkg;

    typedef enum logic [1:0] {
        BM_INT_FETCH = 2'b00,
        BM_EXT_FETCH = 2'b01,
        BM_DATA8     = 2'b10,
        BM_DATA16    = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        P0_HIZ  = 2'b00,
        P0_ADDR = 2'b01,
        P0_DATA = 2'b10
    } p0_sel_e;

    typedef enum logic [1:0] {
        PH_ADDR_A = 2'b00,
        PH_STRB_A = 2'b01,
        PH_ADDR_B = 2'b10,
        PH_STRB_B = 2'b11
    } phase_e;

    typedef struct packed {
        bus_mode_e mode;
        logic      wr;
        logic      ale_off;
        logic      xacc;
    } cyc_cfg_t;

    localparam cyc_cfg_t CFG_RESET = '{mode: BM_INT_FETCH, wr: 1'b0, ale_off: 1'b0, xacc: 1'b0};

endpackage

// File: rtl/esg_timebase.sv
module esg_timebase
    import esg_pkg::*;
#(
    parameter int PHASE_LEN = 3,
    parameter int SUB_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output phase_e           phase,
    output logic [SUB_W-1:0] sub,
    output logic             cyc_last
);

    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(PHASE_LEN - 1);

    phase_e           phase_nxt;
    logic [SUB_W-1:0] sub_nxt;
    logic             phase_end;

    assign phase_end = (sub == SUB_LAST);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_ADDR_A;
            sub   <= '0;
        end else begin
            phase <= phase_nxt;
            sub   <= sub_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        phase_nxt = phase;
        sub_nxt   = sub + 1'b1;
        if (phase_end) begin
            sub_nxt = '0;
            unique case (phase)
                PH_ADDR_A: phase_nxt = PH_STRB_A;
                PH_STRB_A: phase_nxt = PH_ADDR_B;
                PH_ADDR_B: phase_nxt = PH_STRB_B;
                PH_STRB_B: phase_nxt = PH_ADDR_A;
            endcase
        end
    end

    assign cyc_last = phase_end && (phase == PH_STRB_B);

    // R2: phase only moves after its last sub-clock
    p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sub != SUB_LAST) |=> $stable(phase));

    // R2: sub-clock counter restarts after its last value
    p_sub_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sub == SUB_LAST) |=> (sub == '0));

endmodule

// File: rtl/esg_cfg_latch.sv
module esg_cfg_latch
    import esg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cyc_last,
    input  cyc_cfg_t cfg_in,
    output cyc_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (cyc_last) begin
            cfg_q <= cfg_in;
        end
    end

    // R13: configuration frozen inside a machine cycle
    p_cfg_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_last |=> $stable(cfg_q));

endmodule

// File: rtl/esg_strobe_dec.sv
module esg_strobe_dec
    import esg_pkg::*;
#(
    parameter int PHASE_LEN  = 3,
    parameter int ALE_HI_LEN = 2,
    parameter int SUB_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           phase,
    input  logic [SUB_W-1:0] sub,
    input  cyc_cfg_t         cfg,
    output logic             ale,
    output logic             psen_n,
    output p0_sel_e          p0_sel,
    output logic             p2_sel
);

    localparam logic [SUB_W-1:0] SUB_ALE = SUB_W'(PHASE_LEN - ALE_HI_LEN);

    logic addr_ph;
    logic second_half;
    logic ale_win;
    logic is_data;
    logic ale_supp;

    always_comb begin
        addr_ph     = (phase == PH_ADDR_A) || (phase == PH_ADDR_B);
        second_half = (phase == PH_ADDR_B) || (phase == PH_STRB_B);
        ale_win     = addr_ph && (sub >= SUB_ALE);
        is_data     = (cfg.mode == BM_DATA8) || (cfg.mode == BM_DATA16);
        ale_supp    = (cfg.mode == BM_INT_FETCH) && cfg.ale_off && !cfg.xacc;
    end

    // Output process
    always_comb begin
        ale    = ale_win && !ale_supp && !(is_data && second_half);
        psen_n = 1'b1;
        p0_sel = P0_HIZ;
        p2_sel = 1'b0;
        unique case (cfg.mode)
            BM_INT_FETCH: begin
                p0_sel = P0_HIZ;
            end
            BM_EXT_FETCH: begin
                psen_n = addr_ph;
                p0_sel = addr_ph ? P0_ADDR : P0_HIZ;
                p2_sel = 1'b1;
            end
            BM_DATA8, BM_DATA16: begin
                if (phase == PH_ADDR_A) p0_sel = P0_ADDR;
                else                    p0_sel = cfg.wr ? P0_DATA : P0_HIZ;
                p2_sel = (cfg.mode == BM_DATA16);
            end
        endcase
    end

    // R4: address strobe and read strobe never overlap
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale && !psen_n));

    // R10: low address is on port 0 whenever the latch strobe is high on an external cycle
    p_addr_under_ale_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && cfg.mode != BM_INT_FETCH) |-> (p0_sel == P0_ADDR));

    // R5: no read strobe while code runs internally
    p_psen_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == BM_INT_FETCH) |-> psen_n);

    // R12: port-2 source only changes at the start of a machine cycle
    p_p2_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(p2_sel) |-> (phase == PH_ADDR_A && sub == '0));

endmodule

// File: rtl/ext_bus_strobe.sv
module ext_bus_strobe
    import esg_pkg::*;
#(
    parameter int PHASE_LEN  = 3,
    parameter int ALE_HI_LEN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_mode,
    input  logic       data_wr,
    input  logic       ale_off,
    input  logic       xacc_instr,
    output logic       ale,
    output logic       psen_n,
    output logic [1:0] p0_sel,
    output logic       p2_sel
);

    localparam int SUB_W = (PHASE_LEN > 1) ? $clog2(PHASE_LEN) : 1;

    phase_e           phase;
    logic [SUB_W-1:0] sub;
    logic             cyc_last;
    cyc_cfg_t         cfg_in;
    cyc_cfg_t         cfg_q;
    p0_sel_e          p0_sel_enum;

    assign cfg_in = '{mode: bus_mode_e'(bus_mode), wr: data_wr,
                      ale_off: ale_off, xacc: xacc_instr};

    esg_timebase #(
        .PHASE_LEN (PHASE_LEN),
        .SUB_W     (SUB_W)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .sub      (sub),
        .cyc_last (cyc_last)
    );

    esg_cfg_latch u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_last (cyc_last),
        .cfg_in   (cfg_in),
        .cfg_q    (cfg_q)
    );

    esg_strobe_dec #(
        .PHASE_LEN  (PHASE_LEN),
        .ALE_HI_LEN (ALE_HI_LEN),
        .SUB_W      (SUB_W)
    ) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase  (phase),
        .sub    (sub),
        .cfg    (cfg_q),
        .ale    (ale),
        .psen_n (psen_n),
        .p0_sel (p0_sel_enum),
        .p2_sel (p2_sel)
    );

    assign p0_sel = p0_sel_enum;

    // R1: outputs idle while reset is held
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!ale && psen_n && p0_sel == 2'b00 && !p2_sel));

endmodule

// File: tb/ext_bus_strobe_tb.sv
module ext_bus_strobe_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_mode = 2'b01;
    logic       data_wr = 1'b0;
    logic       ale_off = 1'b1;
    logic       xacc_instr = 1'b0;
    logic       ale;
    logic       psen_n;
    logic [1:0] p0_sel;
    logic       p2_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int tb_t   = 0;

    always #5 clk = ~clk;

    ext_bus_strobe u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_mode   (bus_mode),
        .data_wr    (data_wr),
        .ale_off    (ale_off),
        .xacc_instr (xacc_instr),
        .ale        (ale),
        .psen_n     (psen_n),
        .p0_sel     (p0_sel),
        .p2_sel     (p2_sel)
    );

    // Bench time base: position inside the 12-clock machine cycle
    always @(posedge clk) begin
        if (!rst_n) tb_t <= 0;
        else        tb_t <= (tb_t == 11) ? 0 : tb_t + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s t=%0d actual=%0h expected=%0h", req, what, tb_t, act, exp);
        end
    endtask

    // Expected outputs from the requirements
    function automatic bit exp_ale(input int t, input logic [1:0] m, input bit off, input bit xa);
        bit win;
        win = (t == 1 || t == 2 || t == 7 || t == 8);
        if (m == 2'b00 && off && !xa) return 1'b0;      // R7
        if (m[1]) return (t == 1 || t == 2);             // R6
        return win;                                      // R3 R8 R9
    endfunction

    function automatic bit exp_psen_n(input int t, input logic [1:0] m);
        if (m == 2'b01) return !((t >= 3 && t <= 5) || t >= 9);  // R4
        return 1'b1;                                             // R5 R6
    endfunction

    function automatic logic [1:0] exp_p0(input int t, input logic [1:0] m, input bit wr);
        if (m == 2'b00) return 2'b00;                                        // R5
        if (m == 2'b01) return (t <= 2 || (t >= 6 && t <= 8)) ? 2'b01 : 2'b00; // R10
        if (t <= 2) return 2'b01;                                            // R11
        return wr ? 2'b10 : 2'b00;
    endfunction

    function automatic bit exp_p2(input logic [1:0] m);
        return (m == 2'b01 || m == 2'b11);  // R12
    endfunction

    task automatic drive(input logic [1:0] m, input bit wr, input bit off, input bit xa);
        bus_mode = m; data_wr = wr; ale_off = off; xacc_instr = xa;
    endtask

    // Check one machine cycle. If wait_first, drive and wait for the next cycle start.
    // If chg_at >= 0, new inputs are driven after that sample (they must not matter).
    task automatic run_cycle(input logic [1:0] m, input bit wr, input bit off, input bit xa,
                             input bit wait_first, input string over,
                             input int chg_at, input logic [1:0] m2, input bit wr2,
                             input bit off2, input bit xa2);
        string ta, tp, t0, t2;
        int rises, exp_rises;
        bit prev, eprev;
        if (wait_first) begin
            drive(m, wr, off, xa);
            do @(negedge clk); while (tb_t != 0);
        end
        ta = m[1] ? "R6" : (m == 2'b00 && off && !xa) ? "R7" :
             (m == 2'b00 && off) ? "R8" : (m == 2'b01 && off) ? "R9" : "R3";
        tp = (m == 2'b01) ? "R4" : m[1] ? "R6" : "R5";
        t0 = (m == 2'b01) ? "R10" : m[1] ? "R11" : "R5";
        t2 = "R12";
        if (over != "") begin ta = over; tp = over; t0 = over; t2 = over; end
        rises = 0; exp_rises = 0; prev = 1'b0; eprev = 1'b0;
        for (int k = 0; k < 12; k++) begin
            check(ale === exp_ale(k, m, off, xa), ta, "ale", ale, exp_ale(k, m, off, xa));
            check(psen_n === exp_psen_n(k, m), tp, "psen_n", psen_n, exp_psen_n(k, m));
            check(p0_sel === exp_p0(k, m, wr), t0, "p0_sel", p0_sel, exp_p0(k, m, wr));
            check(p2_sel === exp_p2(m), t2, "p2_sel", p2_sel, exp_p2(m));
            if (ale && !prev) rises++;
            if (exp_ale(k, m, off, xa) && !eprev) exp_rises++;
            prev = ale; eprev = exp_ale(k, m, off, xa);
            if (k == chg_at) drive(m2, wr2, off2, xa2);
            @(negedge clk);
        end
        if (exp_rises == 2) check(rises == 2, "R2", "ale rising edges per cycle", rises, 2);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(ale === 1'b0 && psen_n === 1'b1, "R1", "strobes in reset", {ale, psen_n}, 2'b01);
        check(p0_sel === 2'b00 && p2_sel === 1'b0, "R1", "selects in reset", {p0_sel, p2_sel}, 3'b000);
        rst_n = 1'b1;
        // inputs request external fetch with disable set; first cycle must still be internal
        run_cycle(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R1", -1, 2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_int_fetch;    run_cycle(2'b00, 0, 0, 0, 1, "", -1, 0, 0, 0, 0); endtask
    task automatic t_ext_fetch;    run_cycle(2'b01, 0, 0, 0, 1, "", -1, 0, 0, 0, 0); endtask
    task automatic t_ale_off_int;  run_cycle(2'b00, 0, 1, 0, 1, "", -1, 0, 0, 0, 0); endtask
    task automatic t_ale_off_xacc; run_cycle(2'b00, 0, 1, 1, 1, "", -1, 0, 0, 0, 0); endtask
    task automatic t_ale_off_ext;  run_cycle(2'b01, 0, 1, 0, 1, "", -1, 0, 0, 0, 0); endtask
    task automatic t_data8_read;   run_cycle(2'b10, 0, 0, 1, 1, "", -1, 0, 0, 0, 0); endtask
    task automatic t_data8_write;  run_cycle(2'b10, 1, 0, 1, 1, "", -1, 0, 0, 0, 0); endtask
    task automatic t_data16_read;  run_cycle(2'b11, 0, 1, 1, 1, "", -1, 0, 0, 0, 0); endtask
    task automatic t_data16_write; run_cycle(2'b11, 1, 0, 1, 1, "", -1, 0, 0, 0, 0); endtask

    // R13: switch from external fetch to a 16-bit data write in mid-cycle, then check the next cycle
    task automatic t_mid_change;
        run_cycle(2'b01, 0, 0, 0, 1, "R13", 4, 2'b11, 1, 0, 1);
        run_cycle(2'b11, 1, 0, 1, 0, "R13", 5, 2'b00, 0, 1, 0);
        run_cycle(2'b00, 0, 1, 0, 0, "R13", -1, 0, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_int_fetch();
        t_ext_fetch();
        t_ale_off_int();
        t_ale_off_xacc();
        t_ale_off_ext();
        t_data8_read();
        t_data8_write();
        t_data16_read();
        t_data16_write();
        t_mid_change();
        t_ext_fetch();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule